// File: doc/BRIEF.md
# Delay-Adapting Spiking Pattern Learner

This block learns a repeating spatio-temporal spike pattern. It does this by tuning a separate delay on every input line. It never changes any weights. Each input line carries single-cycle spikes. A spike that arrives during a learning window starts a countdown on its own line. When the countdown expires, the line emits one delayed spike. All delayed spikes are ORed onto one serial output line.

While the window runs, the block works out which offset inside the window saw the most coincident delayed spikes. That offset becomes the target time. In the cycle after the window ends, every line whose delayed spike arrived early moves its delay up by one step. Every line whose spike arrived late moves its delay down by one step. After repeated presentations of the same pattern, every delayed spike lands on the same offset. A flag then reports that learning has settled.

The learning path uses only counters, comparators and single-step adders. It contains no multipliers and no digital-to-analog conversion. A load port presets individual delays between windows.

Top module: `spike_delay_learner`

## Requirements
- R1: A spike accepted on line i in the window cycle at offset k appears on `mergedSpike` in the cycle at offset k + delay[i] + 1, if that offset is at most 2^WIN_W - 1. Otherwise it never appears. `mergedSpike` is low outside windows.
- R2: Each line accepts only its first spike of a window. Later spikes on that line in the same window are dropped and produce no output.
- R3: The target time is the earliest offset with the highest count of merged spikes in the window. If no delayed spike arrived, the target time is 0. `tmax` takes the new value one cycle after the update cycle and holds it at all other times.
- R4: In the update cycle, a line whose delayed spike arrived before the new target time gets delay + 1. A line whose spike arrived after it gets delay - 1. A line that arrived exactly on it, or had no arrival, keeps its delay.
- R5: Delays saturate: a delay of 0 never decreases and a delay of 2^WIN_W - 1 never increases. No update wraps around.
- R6: `converged` rises after CONV_WINDOWS consecutive windows in which neither the target time nor any delay changed. It drops after the first window that changes either one.
- R7: A pulse on `loadEn` while idle writes `loadVal` into the delay of line `loadIdx` and clears the run of unchanged windows. A pulse on `loadEn` during a window or an update cycle is ignored.
- R8: `winStart` is ignored while a window or an update cycle is in progress.
- R9: The cycle after `winStart` is sampled while idle has offset 0. The window lasts 2^WIN_W cycles and is followed by exactly one update cycle before the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; sets all delays to 0 |
| winStart | input | 1 | Starts a learning window when the block is idle |
| spikeIn | input | NUM_LINES | Single-cycle input spikes, one bit per line |
| loadEn | input | 1 | Writes one delay while idle |
| loadIdx | input | IDX_W | Line selected by the load |
| loadVal | input | WIN_W | Delay value to load |
| mergedSpike | output | 1 | OR of all delayed spikes |
| tmax | output | WIN_W | Target time of the last completed window |
| converged | output | 1 | Learning has settled |

## Verification
Some properties hold on every cycle, and the in-RTL assertions check those. They cover the offset counter and the single update cycle after each window, the one-fire-per-window limit of each lane, and the one-step-per-window size of a delay change with no wrap at either end. They also check that `tmax` stays still outside the update, that the peak count never shrinks inside a window, that a tie keeps the earlier offset, and that `converged` moves only after an update or a load. Only the bench scenarios can show the exact output timing and the update rule. Those scenarios are a sweep of delays and input offsets, ties between bins, saturation at zero, dropped repeat spikes, ignored mid-window starts and loads, and a full learning run to convergence.

// File: rtl/spl_pkg.sv
package spl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_UPDATE = 2'd2
  } splState_t;

  // strobes sent from the control to the datapath
  typedef struct packed {
    logic clearWin;     // window starts: forget previous window
    logic runStep;      // a window cycle is in progress
    logic applyUpdate;  // single update cycle after the window
    logic loadAccept;   // load port write is allowed this cycle
  } splStrobe_t;

endpackage

// File: rtl/spl_ctrl.sv
module spl_ctrl
  import spl_pkg::*;
#(
  parameter int WIN_W        = 8,
  parameter int CONV_WINDOWS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             winStart,
  input  logic             loadEn,
  input  logic             anyChange,
  output splStrobe_t       strobe,
  output logic [WIN_W-1:0] offset,
  output logic             converged
);

  localparam int STREAK_W = $clog2(CONV_WINDOWS + 1);
  localparam logic [WIN_W-1:0]    LAST_OFF = '1;
  localparam logic [STREAK_W-1:0] STREAK_TOP = STREAK_W'(CONV_WINDOWS);

  splState_t state;
  logic [WIN_W-1:0]    offsetQ;
  logic [STREAK_W-1:0] streakQ;

  always_comb begin
    strobe.clearWin    = (state == ST_IDLE) && winStart;
    strobe.runStep     = (state == ST_RUN);
    strobe.applyUpdate = (state == ST_UPDATE);
    strobe.loadAccept  = (state == ST_IDLE) && loadEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      offsetQ <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (winStart) begin
            state   <= ST_RUN;
            offsetQ <= '0;
          end
        end
        ST_RUN: begin
          if (offsetQ == LAST_OFF) state <= ST_UPDATE;
          else offsetQ <= offsetQ + 1'b1;
        end
        ST_UPDATE: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // count of consecutive windows with no change
  always_ff @(posedge clk) begin
    if (!rstN) begin
      streakQ <= '0;
    end else if (strobe.applyUpdate) begin
      if (anyChange) streakQ <= '0;
      else if (streakQ != STREAK_TOP) streakQ <= streakQ + 1'b1;
    end else if (strobe.loadAccept) begin
      streakQ <= '0;
    end
  end

  assign offset    = offsetQ;
  assign converged = (streakQ == STREAK_TOP);

  // R9
  offset_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && offsetQ != LAST_OFF) |=> (state == ST_RUN && offsetQ == $past(offsetQ) + 1'b1));

  // R9
  window_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && offsetQ == LAST_OFF) |=> (state == ST_UPDATE));

  // R9
  update_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UPDATE) |=> (state == ST_IDLE));

  // R6
  conv_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(converged) |-> $past(strobe.applyUpdate && !anyChange));

  // R6
  conv_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(converged) |-> ($past(strobe.applyUpdate && anyChange) || $past(strobe.loadAccept)));

endmodule

// File: rtl/spl_lane.sv
module spl_lane
  import spl_pkg::*;
#(
  parameter int WIN_W    = 8,
  parameter int IDX_W    = 7,
  parameter int LANE_IDX = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  splStrobe_t       strobe,
  input  logic             spikeIn,
  input  logic [WIN_W-1:0] offset,
  input  logic [WIN_W-1:0] target,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic [WIN_W-1:0] loadVal,
  output logic             fire,
  output logic             delayChange
);

  localparam logic [WIN_W-1:0] DMAX = '1;
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(LANE_IDX);

  logic [WIN_W-1:0] delayQ;
  logic [WIN_W-1:0] cntQ;
  logic [WIN_W-1:0] arrOffQ;
  logic             takenQ;
  logic             arrivedQ;
  logic             loadWr;
  logic             stepUp;
  logic             stepDown;

  assign loadWr = strobe.loadAccept && (loadIdx == MY_IDX);
  assign fire   = strobe.runStep && takenQ && !arrivedQ && (cntQ == '0);

  always_comb begin
    stepUp      = arrivedQ && (arrOffQ < target) && (delayQ != DMAX);
    stepDown    = arrivedQ && (arrOffQ > target) && (delayQ != '0);
    delayChange = stepUp || stepDown;
  end

  // countdown and arrival record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      takenQ   <= 1'b0;
      arrivedQ <= 1'b0;
      cntQ     <= '0;
      arrOffQ  <= '0;
    end else if (strobe.clearWin) begin
      takenQ   <= 1'b0;
      arrivedQ <= 1'b0;
      cntQ     <= '0;
    end else if (strobe.runStep) begin
      if (spikeIn && !takenQ) begin
        takenQ <= 1'b1;
        cntQ   <= delayQ;
      end else if (takenQ && !arrivedQ) begin
        if (cntQ == '0) begin
          arrivedQ <= 1'b1;
          arrOffQ  <= offset;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  // delay register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayQ <= '0;
    end else if (loadWr) begin
      delayQ <= loadVal;
    end else if (strobe.applyUpdate) begin
      if (stepUp) delayQ <= delayQ + 1'b1;
      else if (stepDown) delayQ <= delayQ - 1'b1;
    end
  end

  // R2
  single_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> !fire);

  // R5
  no_wrap_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.applyUpdate && delayQ == '0) |=> (delayQ != DMAX));

  // R5
  no_wrap_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.applyUpdate && delayQ == DMAX) |=> (delayQ != '0));

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.applyUpdate |=> (delayQ == $past(delayQ) || delayQ == $past(delayQ) + 1'b1
                            || delayQ == $past(delayQ) - 1'b1));

endmodule

// File: rtl/spl_datapath.sv
module spl_datapath
  import spl_pkg::*;
#(
  parameter int NUM_LINES = 100,
  parameter int WIN_W     = 8,
  parameter int IDX_W     = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  splStrobe_t           strobe,
  input  logic [NUM_LINES-1:0] spikeIn,
  input  logic [WIN_W-1:0]     offset,
  input  logic [IDX_W-1:0]     loadIdx,
  input  logic [WIN_W-1:0]     loadVal,
  output logic                 mergedSpike,
  output logic [WIN_W-1:0]     tmax,
  output logic                 anyChange
);

  localparam int CNT_W = $clog2(NUM_LINES + 1);

  logic [NUM_LINES-1:0] fireVec;
  logic [NUM_LINES-1:0] chgVec;
  logic [CNT_W-1:0]     binCnt;
  logic [CNT_W-1:0]     bestCnt;
  logic [WIN_W-1:0]     bestOff;
  logic [WIN_W-1:0]     tmaxQ;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lane
    spl_lane #(
      .WIN_W    (WIN_W),
      .IDX_W    (IDX_W),
      .LANE_IDX (i)
    ) lane_i (
      .clk         (clk),
      .rstN        (rstN),
      .strobe      (strobe),
      .spikeIn     (spikeIn[i]),
      .offset      (offset),
      .target      (bestOff),
      .loadIdx     (loadIdx),
      .loadVal     (loadVal),
      .fire        (fireVec[i]),
      .delayChange (chgVec[i])
    );
  end

  // spikes landing at the current offset
  always_comb begin
    binCnt = '0;
    for (int i = 0; i < NUM_LINES; i++) binCnt = binCnt + CNT_W'(fireVec[i]);
  end

  // running peak: each bin is complete in the cycle it is counted
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestCnt <= '0;
      bestOff <= '0;
    end else if (strobe.clearWin) begin
      bestCnt <= '0;
      bestOff <= '0;
    end else if (strobe.runStep && (binCnt > bestCnt)) begin
      bestCnt <= binCnt;
      bestOff <= offset;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) tmaxQ <= '0;
    else if (strobe.applyUpdate) tmaxQ <= bestOff;
  end

  assign mergedSpike = |fireVec;
  assign tmax        = tmaxQ;
  assign anyChange   = (|chgVec) || (bestOff != tmaxQ);

  // R3
  tmax_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.applyUpdate |=> $stable(tmaxQ));

  // R3
  peak_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.runStep |=> (bestCnt >= $past(bestCnt)));

  // R3
  tie_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runStep && binCnt == bestCnt) |=> (bestOff == $past(bestOff)));

  // R1
  merge_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    mergedSpike |-> strobe.runStep);

endmodule

// File: rtl/spike_delay_learner.sv
module spike_delay_learner
  import spl_pkg::*;
#(
  parameter int NUM_LINES    = 100,
  parameter int WIN_W        = 8,
  parameter int CONV_WINDOWS = 4,
  localparam int IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 winStart,
  input  logic [NUM_LINES-1:0] spikeIn,
  input  logic                 loadEn,
  input  logic [IDX_W-1:0]     loadIdx,
  input  logic [WIN_W-1:0]     loadVal,
  output logic                 mergedSpike,
  output logic [WIN_W-1:0]     tmax,
  output logic                 converged
);

  splStrobe_t       strobe;
  logic [WIN_W-1:0] offset;
  logic             anyChange;

  spl_ctrl #(
    .WIN_W        (WIN_W),
    .CONV_WINDOWS (CONV_WINDOWS)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .winStart  (winStart),
    .loadEn    (loadEn),
    .anyChange (anyChange),
    .strobe    (strobe),
    .offset    (offset),
    .converged (converged)
  );

  spl_datapath #(
    .NUM_LINES (NUM_LINES),
    .WIN_W     (WIN_W),
    .IDX_W     (IDX_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .spikeIn     (spikeIn),
    .offset      (offset),
    .loadIdx     (loadIdx),
    .loadVal     (loadVal),
    .mergedSpike (mergedSpike),
    .tmax        (tmax),
    .anyChange   (anyChange)
  );

endmodule

// File: tb/spike_delay_learner_tb_top.sv
module spike_delay_learner_tb_top;

  localparam int N     = 6;
  localparam int WW    = 5;
  localparam int WIN   = 1 << WW;
  localparam int CONV  = 4;
  localparam int IW    = $clog2(N);
  localparam int DMAXV = WIN - 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic          winStart;
  logic [N-1:0]  spikeIn;
  logic          loadEn;
  logic [IW-1:0] loadIdx;
  logic [WW-1:0] loadVal;
  logic          mergedSpike;
  logic [WW-1:0] tmax;
  logic          converged;

  always #10 clk = ~clk;

  spike_delay_learner #(
    .NUM_LINES    (N),
    .WIN_W        (WW),
    .CONV_WINDOWS (CONV)
  ) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .winStart    (winStart),
    .spikeIn     (spikeIn),
    .loadEn      (loadEn),
    .loadIdx     (loadIdx),
    .loadVal     (loadVal),
    .mergedSpike (mergedSpike),
    .tmax        (tmax),
    .converged   (converged)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [N-1:0] sched [WIN];
  int mDelay [N];
  int mTmax   = 0;
  int mStreak = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearSched();
    for (int k = 0; k < WIN; k++) sched[k] = '0;
  endtask

  task automatic loadDelay(input int idx, input int val);
    loadEn  = 1'b1;
    loadIdx = IW'(idx);
    loadVal = WW'(val);
    @(negedge clk);
    loadEn = 1'b0;
    mDelay[idx] = val;
    mStreak = 0;
  endtask

  // one full window; midStart/midLoad at given offset (-1: none)
  task automatic runWindow(input string req, input int midStart, input int midLoad,
                           input int mlIdx, input int mlVal);
    int arr [N];
    int cnt [WIN];
    int best, bo, nt;
    bit changed;
    for (int k = 0; k < WIN; k++) cnt[k] = 0;
    for (int i = 0; i < N; i++) begin
      arr[i] = -1;
      for (int k = 0; k < WIN; k++) begin
        if (sched[k][i] && arr[i] < 0) arr[i] = k + mDelay[i] + 1;
      end
      if (arr[i] > WIN - 1) arr[i] = -1;
      if (arr[i] >= 0) cnt[arr[i]]++;
    end
    best = 0; bo = 0;
    for (int k = 0; k < WIN; k++) if (cnt[k] > best) begin best = cnt[k]; bo = k; end

    winStart = 1'b1;
    @(negedge clk);
    winStart = 1'b0;
    for (int k = 0; k < WIN; k++) begin
      spikeIn  = sched[k];
      winStart = (k == midStart);
      loadEn   = (k == midLoad);
      loadIdx  = IW'(mlIdx);
      loadVal  = WW'(mlVal);
      chk(mergedSpike == (cnt[k] > 0), req, $sformatf("R1 merged at offset %0d", k),
          int'(mergedSpike), int'(cnt[k] > 0));
      @(negedge clk);
    end
    spikeIn = '0; winStart = 1'b0; loadEn = 1'b0;
    // update cycle: tmax still holds the previous value
    chk(tmax == WW'(mTmax), "R9", "tmax during update cycle", int'(tmax), mTmax);
    chk(mergedSpike == 1'b0, "R1", "merged in update cycle", int'(mergedSpike), 0);

    nt = bo;
    changed = (nt != mTmax);
    for (int i = 0; i < N; i++) begin
      if (arr[i] >= 0) begin
        if (arr[i] < nt && mDelay[i] < DMAXV) begin mDelay[i]++; changed = 1; end
        else if (arr[i] > nt && mDelay[i] > 0) begin mDelay[i]--; changed = 1; end
      end
    end
    mTmax = nt;
    if (changed) mStreak = 0;
    else if (mStreak < CONV) mStreak++;
    @(negedge clk);
    chk(tmax == WW'(mTmax), "R3", "tmax after window", int'(tmax), mTmax);
    chk(converged == (mStreak == CONV), "R6", "converged flag", int'(converged), int'(mStreak == CONV));
  endtask

  initial begin
    rstN = 1'b0; winStart = 1'b0; spikeIn = '0; loadEn = 1'b0; loadIdx = '0; loadVal = '0;
    for (int i = 0; i < N; i++) mDelay[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state (R9)
    chk(tmax == '0, "R9", "reset tmax", int'(tmax), 0);
    chk(converged == 1'b0, "R9", "reset converged", int'(converged), 0);
    chk(mergedSpike == 1'b0, "R1", "reset merged", int'(mergedSpike), 0);
    @(negedge clk);

    // R1: sweep every delay value and several input offsets
    for (int d = 0; d < WIN; d++) begin
      loadDelay(d % N, d);
      clearSched();
      sched[d % 3][d % N] = 1'b1;
      runWindow("R1", -1, -1, 0, 0);
    end

    // R3: tie between offset 5 and offset 9 keeps the earlier one
    for (int i = 0; i < N; i++) loadDelay(i, 0);
    clearSched();
    sched[4][0] = 1'b1; sched[4][1] = 1'b1;
    sched[8][2] = 1'b1; sched[8][3] = 1'b1;
    runWindow("R3", -1, -1, 0, 0);
    chk(tmax == 5, "R3", "tie picks earliest offset", int'(tmax), 5);

    // R5: late line with delay 0 stays at 0
    for (int i = 0; i < N; i++) loadDelay(i, 0);
    clearSched();
    sched[10][0] = 1'b1; sched[4][1] = 1'b1; sched[4][2] = 1'b1;
    runWindow("R5", -1, -1, 0, 0);
    clearSched();
    sched[0][0] = 1'b1;
    runWindow("R5", -1, -1, 0, 0);
    chk(tmax == 1, "R5", "saturated delay probe", int'(tmax), 1);

    // R4: early and late lines each step one toward the peak
    loadDelay(0, 2); loadDelay(1, 6); loadDelay(2, 6); loadDelay(3, 10);
    clearSched();
    sched[0][0] = 1'b1; sched[0][1] = 1'b1; sched[0][2] = 1'b1; sched[0][3] = 1'b1;
    runWindow("R4", -1, -1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      clearSched();
      sched[0][i] = 1'b1;
      runWindow("R4", -1, -1, 0, 0);
    end

    // R2: repeat spikes on one line are dropped
    loadDelay(0, 10);
    clearSched();
    sched[0][0] = 1'b1; sched[3][0] = 1'b1; sched[20][0] = 1'b1;
    runWindow("R2", -1, -1, 0, 0);
    chk(tmax == 11, "R2", "only first spike counted", int'(tmax), 11);

    // R8: start strobe inside a window is ignored
    loadDelay(0, 2);
    clearSched();
    sched[10][0] = 1'b1;
    runWindow("R8", 5, -1, 0, 0);
    chk(tmax == 13, "R8", "window kept its timing", int'(tmax), 13);

    // R7: load inside a window is ignored, probe shows the old delay
    clearSched();
    sched[0][1] = 1'b1;
    runWindow("R7", -1, 3, 0, 20);
    clearSched();
    sched[0][0] = 1'b1;
    runWindow("R7", -1, -1, 0, 0);
    chk(tmax == 3, "R7", "mid-window load ignored", int'(tmax), 3);

    // R4/R6: learn a fixed pattern until convergence
    loadDelay(0, 3); loadDelay(1, 7); loadDelay(2, 1);
    loadDelay(3, 12); loadDelay(4, 5); loadDelay(5, 9);
    clearSched();
    sched[2][0] = 1'b1; sched[0][1] = 1'b1; sched[6][2] = 1'b1;
    sched[1][3] = 1'b1; sched[4][4] = 1'b1; sched[3][5] = 1'b1;
    for (int w = 0; w < 12; w++) runWindow("R4", -1, -1, 0, 0);
    chk(converged == 1'b1, "R6", "pattern learned", int'(converged), 1);
    chk(tmax == 8, "R4", "learned target time", int'(tmax), 8);

    // R7: a load while idle clears the converged state
    loadDelay(2, 0);
    chk(converged == 1'b0, "R7", "load drops converged", int'(converged), 0);

    // R6: a changing window keeps it low
    runWindow("R6", -1, -1, 0, 0);
    chk(converged == 1'b0, "R6", "converged low after change", int'(converged), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule